// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the bus-capture logic of a parallel NOR flash and interprets the stream of captured write cycles. Each write carries a word address, the extra byte-select bit used in 8-bit bus mode, a 16-bit data value and a flag that says whether the cycle was made in byte or word mode. The decoder recognises the multi-cycle unlock protocol and turns it into outputs for a separate program/erase engine. These outputs are persistent mode levels (auto-select, unlock bypass, erase active, suspended), one-cycle event pulses (chip erase, block erase, suspend, resume, read/reset) and a program request that carries an address and data.

Only address bits 10..0, the byte-select bit and data bits 7..0 take part in command matching. Block erase is open-ended. After the first block is chosen, further block addresses may be added until a window of `ERASE_TIMEOUT` clock cycles passes with no new block. The window then closes and the block-erase pulse presents the accumulated 11-bit block mask.

The write input is a valid/ready stream. The decoder holds `wr_ready` high except while a program request is waiting on the engine. A write is taken on a rising edge where both `wr_valid` and `wr_ready` are high. The program request is a valid/ready stream as well. Once raised, `prog_valid` and its payload hold unchanged until the engine shows `prog_ready`, and no write is taken in that time.

Top module: `fcd_cmd_decoder`

## Requirements
- R1: The first unlock write is data AAh and the second is 55h. In word mode these go to addresses 555h and 2AAh, with the byte-select bit ignored. In byte mode they go to the same word addresses with byte-select 0 and 1 respectively, which are byte addresses AAAh and 555h. Address bits above bit 10 and data bits 15..8 never affect command decoding.
- R2: Two unlock writes followed by 90h at the first unlock address set `autosel_mode`. It stays set across later unlock writes and clears on any other completed command or abort.
- R3: Two unlock writes, then A0h at the first unlock address, then one more write of any address and data raise `prog_valid` one cycle later, carrying that write's address, byte-select bit, mode flag and full 16-bit data. `prog_valid` and its payload stay stable until `prog_ready` is high at an edge. `wr_ready` is low for the whole of that time.
- R4: Two unlock writes then 20h at the first unlock address enter bypass mode (`bypass_mode`=1). In this mode A0h followed by one address/data write issues a program request with no unlock cycles. 90h followed by 00h leaves bypass mode.
- R5: Unlock, 80h, unlock, then 10h at the first unlock address pulse `chip_erase_go` for one cycle. They also set `erase_active` and set all 11 bits of `blk_mask`.
- R6: Unlock, 80h, unlock, then 30h at any address opens the erase window (`erase_window`=1), with `blk_mask` holding only that block's bit. Each further 30h write ORs in its block's bit and restarts the count. `ERASE_TIMEOUT` edges after the last accepted 30h, `blk_erase_go` pulses, `erase_window` drops, `timeout_flag` sets and `erase_active` sets.
- R7: The block index is taken from the word address, and bit k of `blk_mask` stands for block k. With `BOOT_TOP`=1, the default, blocks 0..6 are 32K-word blocks at 00000h-37FFFh. Block 7 covers 38000h-3BFFFh, block 8 covers 3C000h-3CFFFh, block 9 covers 3D000h-3DFFFh and block 10 covers 3E000h-3FFFFh. With `BOOT_TOP`=0 the layout is mirrored: block 0 covers 00000h-01FFFh and block 10 covers 38000h-3FFFFh.
- R8: A write of F0h pulses `read_reset` and returns the decoder to read mode. It clears auto-select, bypass, erase active, suspended, the erase window, the mask, `timeout_flag` and `err_flag`. This applies in every state, busy or not, except the data cycle of a program when the engine is idle.
- R9: Any other write that does not continue a valid sequence aborts it. `autosel_mode` and `bypass_mode` drop, and an open erase window closes with its mask cleared and no erase pulse.
- R10: While `eng_busy` is high, every write other than F0h and B0h is consumed and ignored, and all modes keep their values.
- R11: B0h while `erase_active`=1 and not suspended pulses `erase_suspend` and sets `suspended`. In read mode, 30h while suspended pulses `erase_resume` and clears `suspended`.
- R12: While suspended, a program whose address falls in a block set in `blk_mask` is rejected: no program request is issued and `err_flag` sets.
- R13: `eng_done` while `erase_active`=1 and not suspended clears `erase_active` and `blk_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Captured write present |
| wr_ready | output | 1 | Decoder can take a write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_alsb | input | 1 | Byte-select address bit, used in byte mode |
| wr_byte | input | 1 | 1 = write made in byte mode |
| wr_data | input | 16 | Write data |
| eng_busy | input | 1 | Engine is programming or erasing |
| eng_done | input | 1 | Engine finished its operation (pulse) |
| prog_valid | output | 1 | Program request pending |
| prog_ready | input | 1 | Engine takes the program request |
| prog_addr | output | ADDR_W | Program word address |
| prog_alsb | output | 1 | Program byte-select bit |
| prog_byte | output | 1 | Program made in byte mode |
| prog_data | output | 16 | Program data |
| chip_erase_go | output | 1 | Chip erase start pulse |
| blk_erase_go | output | 1 | Block erase start pulse |
| blk_mask | output | 11 | Selected erase blocks |
| erase_suspend | output | 1 | Suspend request pulse |
| erase_resume | output | 1 | Resume request pulse |
| read_reset | output | 1 | Read/reset pulse |
| autosel_mode | output | 1 | Identification read mode |
| bypass_mode | output | 1 | Unlock bypass active |
| erase_active | output | 1 | An erase has been started and not finished |
| suspended | output | 1 | Erase is suspended |
| erase_window | output | 1 | Block list still open |
| timeout_flag | output | 1 | Block list closed by timeout |
| err_flag | output | 1 | A program was rejected |

## Verification
Each accepted write acts at the edge that takes it, so modes, pulses and `prog_valid` are due one cycle after the write is presented. The block-erase pulse is due `ERASE_TIMEOUT` edges after the last accepted 30h. The bench drives inputs just after a rising edge and steps a behavioural model at the falling edge, using the inputs that the next rising edge will sample. At each falling edge it first compares every output with the model's state for the current cycle, so each result is checked in exactly the cycle it is due. Point checks for specific requirements are also taken at falling edges after the write that causes them.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int NUM_BLOCKS = 11;

  localparam logic [7:0] OP_UNLOCK_A = 8'hAA;
  localparam logic [7:0] OP_UNLOCK_B = 8'h55;
  localparam logic [7:0] OP_AUTOSEL  = 8'h90;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_BYPASS   = 8'h20;
  localparam logic [7:0] OP_ERASE    = 8'h80;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_BLOCK    = 8'h30;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_RESET    = 8'hF0;
  localparam logic [7:0] OP_BYP_EXIT = 8'h00;

  localparam logic [10:0] UNLOCK_ADDR_FIRST  = 11'h555;
  localparam logic [10:0] UNLOCK_ADDR_SECOND = 11'h2AA;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG,
    SQ_ERS1, SQ_ERS2, SQ_ERS3, SQ_BLKWIN,
    SQ_BYP, SQ_BYP_PROG, SQ_BYP_EXIT
  } seq_e;
endpackage

// File: rtl/fcd_unlock_match.sv
module fcd_unlock_match
  import fcd_pkg::*;
(
  input  logic [10:0] addr_low,
  input  logic        alsb,
  input  logic        byte_mode,
  output logic        hit_first,
  output logic        hit_second
);
  // In byte mode the byte-select bit extends the address by one LSB.
  always_comb begin
    hit_first  = (addr_low == UNLOCK_ADDR_FIRST)  && (!byte_mode || !alsb);
    hit_second = (addr_low == UNLOCK_ADDR_SECOND) && (!byte_mode ||  alsb);
  end
endmodule

// File: rtl/fcd_block_map.sv
module fcd_block_map
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter bit BOOT_TOP = 1'b1
)(
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_BLOCKS-1:0] blk_oh
);
  localparam int RW = ADDR_W - 3;  // bits inside one main region

  logic [ADDR_W-1:0] a;
  logic [3:0]        idx_t;
  logic [3:0]        idx;

  // Bottom layout is the top layout seen through an inverted address.
  generate
    if (BOOT_TOP) begin : g_top
      assign a   = addr;
      assign idx = idx_t;
    end else begin : g_bottom
      assign a   = ~addr;
      assign idx = 4'd10 - idx_t;
    end
  endgenerate

  always_comb begin
    if (a[ADDR_W-1:RW] != 3'b111)  idx_t = {1'b0, a[ADDR_W-1:RW]};
    else if (!a[RW-1])             idx_t = 4'd7;
    else if (a[RW-2])              idx_t = 4'd10;
    else if (!a[RW-3])             idx_t = 4'd8;
    else                           idx_t = 4'd9;
  end

  assign blk_oh = NUM_BLOCKS'(1) << idx;
endmodule

// File: rtl/fcd_erase_window.sv
module fcd_erase_window
  import fcd_pkg::*;
#(
  parameter int TIMEOUT = 64
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  open_i,
  input  logic                  add_i,
  input  logic                  abort_i,
  input  logic                  chip_i,
  input  logic                  done_i,
  input  logic                  wr_seen_i,
  input  logic [NUM_BLOCKS-1:0] blk_oh_i,
  output logic                  win_o,
  output logic [NUM_BLOCKS-1:0] mask_o,
  output logic                  tmo_o,
  output logic                  expire_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] cnt;

  assign expire_o = win_o && !wr_seen_i && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_o  <= 1'b0;
      mask_o <= '0;
      tmo_o  <= 1'b0;
      cnt    <= '0;
    end else if (clr_i) begin
      win_o  <= 1'b0;
      mask_o <= '0;
      tmo_o  <= 1'b0;
      cnt    <= '0;
    end else if (open_i) begin
      win_o  <= 1'b1;
      mask_o <= blk_oh_i;
      tmo_o  <= 1'b0;
      cnt    <= CW'(TIMEOUT);
    end else if (add_i) begin
      mask_o <= mask_o | blk_oh_i;
      cnt    <= CW'(TIMEOUT);
    end else if (abort_i) begin
      win_o  <= 1'b0;
      mask_o <= '0;
    end else if (chip_i) begin
      mask_o <= '1;
      tmo_o  <= 1'b0;
    end else if (done_i) begin
      mask_o <= '0;
    end else if (expire_o) begin
      win_o  <= 1'b0;
      tmo_o  <= 1'b1;
    end else if (win_o && !wr_seen_i) begin
      cnt    <= cnt - CW'(1);
    end
  end

  assert_expire_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (mask_o != '0));

  assert_window_tmo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> !tmo_o);
endmodule

// File: rtl/fcd_cmd_decoder.sv
module fcd_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter bit BOOT_TOP      = 1'b1,
  parameter int ERASE_TIMEOUT = 64
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic                  wr_alsb,
  input  logic                  wr_byte,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  eng_busy,
  input  logic                  eng_done,
  output logic                  prog_valid,
  input  logic                  prog_ready,
  output logic [ADDR_W-1:0]     prog_addr,
  output logic                  prog_alsb,
  output logic                  prog_byte,
  output logic [DATA_W-1:0]     prog_data,
  output logic                  chip_erase_go,
  output logic                  blk_erase_go,
  output logic [NUM_BLOCKS-1:0] blk_mask,
  output logic                  erase_suspend,
  output logic                  erase_resume,
  output logic                  read_reset,
  output logic                  autosel_mode,
  output logic                  bypass_mode,
  output logic                  erase_active,
  output logic                  suspended,
  output logic                  erase_window,
  output logic                  timeout_flag,
  output logic                  err_flag
);
  seq_e seq, seq_n;
  logic acc;
  logic [7:0] d;
  logic hit1, hit2;
  logic [NUM_BLOCKS-1:0] blk_oh;
  logic autosel_n, err_n, ers_n, susp_n;
  logic ev_chip, ev_susp, ev_res, ev_rst, do_prog, pv_set, bad, data_cyc;
  logic w_clr, w_open, w_add, w_abort, w_chip, w_done, w_expire;

  assign wr_ready = !prog_valid;
  assign acc      = wr_valid && wr_ready;
  assign d        = wr_data[7:0];
  assign data_cyc = (seq == SQ_PROG) || (seq == SQ_BYP_PROG);
  assign bypass_mode = (seq == SQ_BYP) || (seq == SQ_BYP_PROG) || (seq == SQ_BYP_EXIT);

  fcd_unlock_match u_match (
    .addr_low  (wr_addr[10:0]),
    .alsb      (wr_alsb),
    .byte_mode (wr_byte),
    .hit_first (hit1),
    .hit_second(hit2)
  );

  fcd_block_map #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP)) u_map (
    .addr  (wr_addr),
    .blk_oh(blk_oh)
  );

  fcd_erase_window #(.TIMEOUT(ERASE_TIMEOUT)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (w_clr),
    .open_i   (w_open),
    .add_i    (w_add),
    .abort_i  (w_abort),
    .chip_i   (w_chip),
    .done_i   (w_done),
    .wr_seen_i(acc),
    .blk_oh_i (blk_oh),
    .win_o    (erase_window),
    .mask_o   (blk_mask),
    .tmo_o    (timeout_flag),
    .expire_o (w_expire)
  );

  always_comb begin
    seq_n = seq;  autosel_n = autosel_mode;  err_n = err_flag;
    ers_n = erase_active;  susp_n = suspended;
    ev_chip = 1'b0; ev_susp = 1'b0; ev_res = 1'b0; ev_rst = 1'b0;
    do_prog = 1'b0; pv_set = 1'b0; bad = 1'b0;
    w_clr = 1'b0; w_open = 1'b0; w_add = 1'b0; w_abort = 1'b0;
    w_chip = 1'b0; w_done = 1'b0;
    if (acc) begin
      if (data_cyc && !eng_busy) begin
        do_prog = 1'b1;
        if (seq == SQ_PROG) begin
          seq_n = SQ_IDLE;
          autosel_n = 1'b0;
        end else begin
          seq_n = SQ_BYP;
        end
      end else if (d == OP_RESET) begin
        seq_n = SQ_IDLE;  autosel_n = 1'b0;  err_n = 1'b0;
        ers_n = 1'b0;  susp_n = 1'b0;  ev_rst = 1'b1;  w_clr = 1'b1;
      end else if (d == OP_SUSPEND && erase_active && !suspended) begin
        ev_susp = 1'b1;
        susp_n  = 1'b1;
      end else if (!eng_busy) begin
        unique case (seq)
          SQ_IDLE: begin
            if (d == OP_UNLOCK_A && hit1) seq_n = SQ_UNL1;
            else if (d == OP_BLOCK && suspended) begin
              ev_res = 1'b1;
              susp_n = 1'b0;
            end else bad = 1'b1;
          end
          SQ_UNL1: if (d == OP_UNLOCK_B && hit2) seq_n = SQ_UNL2; else bad = 1'b1;
          SQ_UNL2: begin
            if (!hit1) bad = 1'b1;
            else if (d == OP_AUTOSEL) begin
              autosel_n = 1'b1;
              seq_n = SQ_IDLE;
            end else if (d == OP_PROGRAM) seq_n = SQ_PROG;
            else if (d == OP_BYPASS) begin
              autosel_n = 1'b0;
              seq_n = SQ_BYP;
            end else if (d == OP_ERASE && !suspended) begin
              autosel_n = 1'b0;
              seq_n = SQ_ERS1;
            end else bad = 1'b1;
          end
          SQ_ERS1: if (d == OP_UNLOCK_A && hit1) seq_n = SQ_ERS2; else bad = 1'b1;
          SQ_ERS2: if (d == OP_UNLOCK_B && hit2) seq_n = SQ_ERS3; else bad = 1'b1;
          SQ_ERS3: begin
            if (d == OP_CHIP && hit1) begin
              ev_chip = 1'b1;  ers_n = 1'b1;  w_chip = 1'b1;  seq_n = SQ_IDLE;
            end else if (d == OP_BLOCK) begin
              w_open = 1'b1;
              seq_n  = SQ_BLKWIN;
            end else bad = 1'b1;
          end
          SQ_BLKWIN: if (d == OP_BLOCK) w_add = 1'b1; else bad = 1'b1;
          SQ_BYP: begin
            if (d == OP_PROGRAM) seq_n = SQ_BYP_PROG;
            else if (d == OP_AUTOSEL) seq_n = SQ_BYP_EXIT;
            else bad = 1'b1;
          end
          SQ_BYP_EXIT: if (d == OP_BYP_EXIT) seq_n = SQ_IDLE; else bad = 1'b1;
          default: bad = 1'b1;
        endcase
        if (bad) begin
          seq_n = SQ_IDLE;
          autosel_n = 1'b0;
          if (seq == SQ_BLKWIN) w_abort = 1'b1;
        end
      end
    end
    if (w_expire) begin
      seq_n = SQ_IDLE;
      ers_n = 1'b1;
    end
    if (eng_done && erase_active && !suspended && !w_clr) begin
      ers_n  = 1'b0;
      w_done = 1'b1;
    end
    if (do_prog) begin
      if (suspended && ((blk_mask & blk_oh) != '0)) err_n = 1'b1;
      else pv_set = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq           <= SQ_IDLE;
      autosel_mode  <= 1'b0;
      err_flag      <= 1'b0;
      erase_active  <= 1'b0;
      suspended     <= 1'b0;
      chip_erase_go <= 1'b0;
      blk_erase_go  <= 1'b0;
      erase_suspend <= 1'b0;
      erase_resume  <= 1'b0;
      read_reset    <= 1'b0;
      prog_valid    <= 1'b0;
      prog_addr     <= '0;
      prog_alsb     <= 1'b0;
      prog_byte     <= 1'b0;
      prog_data     <= '0;
    end else begin
      seq           <= seq_n;
      autosel_mode  <= autosel_n;
      err_flag      <= err_n;
      erase_active  <= ers_n;
      suspended     <= susp_n;
      chip_erase_go <= ev_chip;
      blk_erase_go  <= w_expire;
      erase_suspend <= ev_susp;
      erase_resume  <= ev_res;
      read_reset    <= ev_rst;
      if (pv_set) begin
        prog_valid <= 1'b1;
        prog_addr  <= wr_addr;
        prog_alsb  <= wr_alsb;
        prog_byte  <= wr_byte;
        prog_data  <= wr_data;
      end else if (prog_valid && prog_ready) begin
        prog_valid <= 1'b0;
      end
    end
  end

  assert_prog_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && !prog_ready) |=> (prog_valid && $stable(prog_addr) && $stable(prog_data)));

  assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_erase_go, blk_erase_go, erase_suspend, erase_resume, read_reset}));

  assert_susp_erasing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> erase_active);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && acc && d != OP_RESET && d != OP_SUSPEND)
      |=> ($stable(autosel_mode) && $stable(bypass_mode)));
endmodule

// File: tb/tb_fcd_cmd_decoder.sv
`timescale 1ns/100ps
module tb_fcd_cmd_decoder;
  localparam int AW = 18;
  localparam int TMO = 6;
  localparam int QI = 0, QU1 = 1, QU2 = 2, QP = 3, QE1 = 4, QE2 = 5, QE3 = 6,
                 QW = 7, QB = 8, QBP = 9, QBX = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_alsb = 1'b0, wr_byte = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic eng_busy = 1'b0, eng_done = 1'b0, prog_ready = 1'b1;
  logic wr_ready, prog_valid, prog_alsb, prog_byte;
  logic [AW-1:0] prog_addr;
  logic [15:0] prog_data;
  logic chip_erase_go, blk_erase_go, erase_suspend, erase_resume, read_reset;
  logic [10:0] blk_mask;
  logic autosel_mode, bypass_mode, erase_active, suspended, erase_window;
  logic timeout_flag, err_flag;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fcd_cmd_decoder #(.ERASE_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_alsb(wr_alsb), .wr_byte(wr_byte), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_done(eng_done), .prog_valid(prog_valid),
    .prog_ready(prog_ready), .prog_addr(prog_addr), .prog_alsb(prog_alsb),
    .prog_byte(prog_byte), .prog_data(prog_data), .chip_erase_go(chip_erase_go),
    .blk_erase_go(blk_erase_go), .blk_mask(blk_mask), .erase_suspend(erase_suspend),
    .erase_resume(erase_resume), .read_reset(read_reset), .autosel_mode(autosel_mode),
    .bypass_mode(bypass_mode), .erase_active(erase_active), .suspended(suspended),
    .erase_window(erase_window), .timeout_flag(timeout_flag), .err_flag(err_flag)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Block index from a word address, top-boot layout, by address ranges.
  function automatic logic [10:0] blk_bit(int wa);
    int k;
    if (wa < 7 * 32768) k = wa / 32768;
    else if (wa < 229376 + 16384) k = 7;
    else if (wa < 229376 + 20480) k = 8;
    else if (wa < 229376 + 24576) k = 9;
    else k = 10;
    return 11'(1) << k;
  endfunction

  // Behavioural reference state
  int m_seq = QI, m_cnt = 0;
  bit m_as, m_err, m_ers, m_susp, m_pv, m_pal, m_pb, m_win, m_tmo;
  bit m_chip, m_blk, m_sp, m_rp, m_rst;
  logic [AW-1:0] m_pa;
  logic [15:0] m_pd;
  logic [10:0] m_mask;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_seq = QI; m_cnt = 0; m_as = 0; m_err = 0; m_ers = 0; m_susp = 0; m_pv = 0;
      m_pal = 0; m_pb = 0; m_win = 0; m_tmo = 0; m_chip = 0; m_blk = 0; m_sp = 0;
      m_rp = 0; m_rst = 0; m_pa = '0; m_pd = '0; m_mask = '0;
    end else begin
      chk("R3", "wr_ready", wr_ready, !m_pv);
      chk("R3", "prog_valid", prog_valid, m_pv);
      if (m_pv) begin
        chk("R3", "prog_addr", prog_addr, m_pa);
        chk("R3", "prog_data", prog_data, m_pd);
        chk("R3", "prog_alsb/byte", {prog_alsb, prog_byte}, {m_pal, m_pb});
      end
      chk("R5", "chip_erase_go", chip_erase_go, m_chip);
      chk("R6", "blk_erase_go", blk_erase_go, m_blk);
      chk("R6", "blk_mask", blk_mask, m_mask);
      chk("R6", "erase_window", erase_window, m_win);
      chk("R6", "timeout_flag", timeout_flag, m_tmo);
      chk("R11", "suspend/resume pulses", {erase_suspend, erase_resume}, {m_sp, m_rp});
      chk("R11", "suspended", suspended, m_susp);
      chk("R8", "read_reset", read_reset, m_rst);
      chk("R2", "autosel_mode", autosel_mode, m_as);
      chk("R4", "bypass_mode", bypass_mode, (m_seq == QB || m_seq == QBP || m_seq == QBX));
      chk("R13", "erase_active", erase_active, m_ers);
      chk("R12", "err_flag", err_flag, m_err);
      model_step();
    end
  end

  task automatic model_step();
    bit acc, h1, h2, bad, do_prog, was_win;
    logic [7:0] dd;
    int s;
    acc = wr_valid && !m_pv;
    s = m_seq;
    was_win = m_win;
    m_chip = 0; m_blk = 0; m_sp = 0; m_rp = 0; m_rst = 0; do_prog = 0;
    if (m_pv && prog_ready) m_pv = 0;
    dd = wr_data[7:0];
    h1 = (wr_addr[10:0] == 11'h555) && (!wr_byte || !wr_alsb);
    h2 = (wr_addr[10:0] == 11'h2AA) && (!wr_byte || wr_alsb);
    if (acc) begin
      if ((s == QP || s == QBP) && !eng_busy) begin
        do_prog = 1;
        if (s == QP) begin m_seq = QI; m_as = 0; end else m_seq = QB;
      end else if (dd == 8'hF0) begin
        m_seq = QI; m_as = 0; m_err = 0; m_ers = 0; m_susp = 0; m_rst = 1;
        m_win = 0; m_mask = '0; m_tmo = 0; m_cnt = 0;
      end else if (dd == 8'hB0 && m_ers && !m_susp) begin
        m_sp = 1; m_susp = 1;
      end else if (!eng_busy) begin
        bad = 0;
        if (s == QI && dd == 8'hAA && h1) m_seq = QU1;
        else if (s == QI && dd == 8'h30 && m_susp) begin m_rp = 1; m_susp = 0; end
        else if (s == QU1 && dd == 8'h55 && h2) m_seq = QU2;
        else if (s == QU2 && h1 && dd == 8'h90) begin m_as = 1; m_seq = QI; end
        else if (s == QU2 && h1 && dd == 8'hA0) m_seq = QP;
        else if (s == QU2 && h1 && dd == 8'h20) begin m_as = 0; m_seq = QB; end
        else if (s == QU2 && h1 && dd == 8'h80 && !m_susp) begin m_as = 0; m_seq = QE1; end
        else if (s == QE1 && dd == 8'hAA && h1) m_seq = QE2;
        else if (s == QE2 && dd == 8'h55 && h2) m_seq = QE3;
        else if (s == QE3 && dd == 8'h10 && h1) begin
          m_chip = 1; m_ers = 1; m_mask = '1; m_tmo = 0; m_seq = QI;
        end else if (s == QE3 && dd == 8'h30) begin
          m_win = 1; m_mask = blk_bit(int'(wr_addr)); m_tmo = 0; m_cnt = TMO; m_seq = QW;
        end else if (s == QW && dd == 8'h30) begin
          m_mask = m_mask | blk_bit(int'(wr_addr)); m_cnt = TMO;
        end else if (s == QB && dd == 8'hA0) m_seq = QBP;
        else if (s == QB && dd == 8'h90) m_seq = QBX;
        else if (s == QBX && dd == 8'h00) m_seq = QI;
        else bad = 1;
        if (bad) begin
          m_seq = QI; m_as = 0;
          if (s == QW) begin m_win = 0; m_mask = '0; end
        end
      end
    end else if (was_win) begin
      if (m_cnt == 1) begin
        m_blk = 1; m_win = 0; m_tmo = 1; m_ers = 1; m_seq = QI;
      end else m_cnt = m_cnt - 1;
    end
    if (eng_done && m_ers && !m_susp && !m_rst && !m_blk) begin
      m_ers = 0; m_mask = '0;
    end
    if (do_prog) begin
      if (m_susp && ((m_mask & blk_bit(int'(wr_addr))) != '0)) m_err = 1;
      else begin
        m_pv = 1; m_pa = wr_addr; m_pd = wr_data; m_pal = wr_alsb; m_pb = wr_byte;
      end
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic l, logic b, logic [15:0] dv);
    @(posedge clk); #1;
    wr_valid = 1; wr_addr = a; wr_alsb = l; wr_byte = b; wr_data = dv;
    forever begin
      @(negedge clk);
      if (wr_ready) break;
    end
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic unl(logic b);
    wr(18'h00555, 1'b0, b, 16'h00AA);
    wr(18'h002AA, b, b, 16'h0055);
  endtask

  task automatic cmd(logic b, logic [7:0] c);
    unl(b);
    wr(18'h00555, 1'b0, b, {8'h00, c});
  endtask

  task automatic pulse_done();
    @(posedge clk); #1 eng_done = 1;
    @(posedge clk); #1 eng_done = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R8", "reset autosel", autosel_mode, 0);
    chk("R8", "reset window", erase_window, 0);

    // Word-mode auto-select with upper address bits set
    wr(18'h3F555, 0, 0, 16'hFFAA);
    wr(18'h1A2AA, 0, 0, 16'h0055);
    wr(18'h25555, 0, 0, 16'h0090);
    @(negedge clk); chk("R1", "word autosel, upper bits ignored", autosel_mode, 1);
    unl(0);
    @(negedge clk); chk("R2", "autosel kept across unlock", autosel_mode, 1);
    wr(18'h00000, 0, 0, 16'h00F0);
    @(negedge clk); chk("R8", "single F0 leaves autosel", autosel_mode, 0);

    // Byte-mode auto-select, then aborts
    cmd(1, 8'h90);
    @(negedge clk); chk("R1", "byte autosel", autosel_mode, 1);
    wr(18'h00555, 1, 1, 16'h00AA);
    @(negedge clk); chk("R9", "wrong byte address aborts", autosel_mode, 0);
    cmd(0, 8'h90);
    wr(18'h01234, 0, 0, 16'h0030);
    @(negedge clk); chk("R9", "resume while not suspended aborts", autosel_mode, 0);

    // Program with back-pressure
    prog_ready = 0;
    cmd(0, 8'hA0);
    wr(18'h12345, 1, 0, 16'hBEEF);
    @(negedge clk); chk("R3", "wr_ready low while pending", wr_ready, 0);
    idle(4);
    prog_ready = 1;
    idle(2);
    unl(0);
    wr(18'h00000, 0, 0, 16'h00F0);

    // Unlock bypass
    cmd(0, 8'h20);
    @(negedge clk); chk("R4", "bypass entered", bypass_mode, 1);
    wr(18'h00100, 0, 0, 16'h00A0);
    wr(18'h00100, 0, 0, 16'h1234);
    wr(18'h00200, 0, 0, 16'h00A0);
    wr(18'h00200, 0, 0, 16'h56F0);
    wr(18'h00000, 0, 0, 16'h0090);
    wr(18'h00000, 0, 0, 16'h0000);
    @(negedge clk); chk("R4", "bypass left", bypass_mode, 0);

    // Chip erase, busy, suspend, rejected program, resume, done
    cmd(0, 8'h80); unl(0); wr(18'h00555, 0, 0, 16'h0010);
    eng_busy = 1;
    cmd(0, 8'h90);
    @(negedge clk); chk("R10", "busy ignores autosel", autosel_mode, 0);
    wr(18'h00000, 0, 0, 16'h00B0);
    @(negedge clk); chk("R11", "suspended after B0", suspended, 1);
    eng_busy = 0;
    cmd(0, 8'hA0); wr(18'h01000, 0, 0, 16'h4321);
    @(negedge clk); chk("R12", "program rejected after chip erase", err_flag, 1);
    wr(18'h00000, 0, 0, 16'h0030);
    @(negedge clk); chk("R11", "resumed", suspended, 0);
    eng_busy = 1; idle(3);
    pulse_done(); eng_busy = 0;
    @(negedge clk); chk("R13", "done ends erase", erase_active, 0);
    wr(18'h00000, 0, 0, 16'h00F0);
    @(negedge clk); chk("R8", "F0 clears err", err_flag, 0);

    // Byte-mode block erase with three blocks
    cmd(1, 8'h80); unl(1);
    wr(18'h10000, 0, 1, 16'h0030);
    wr(18'h3E000, 1, 1, 16'h0030);
    wr(18'h3C800, 0, 1, 16'h0030);
    idle(TMO + 3);
    @(negedge clk);
    chk("R7", "block mask", blk_mask, 11'b101_0000_0100);
    chk("R6", "timeout flag", timeout_flag, 1);
    eng_busy = 1;
    wr(18'h00000, 0, 0, 16'h00B0);
    eng_busy = 0;
    cmd(0, 8'hA0); wr(18'h10010, 0, 0, 16'h0101);
    @(negedge clk); chk("R12", "program in erased block rejected", err_flag, 1);
    cmd(0, 8'hA0); wr(18'h28000, 0, 0, 16'h0202);
    idle(2);
    wr(18'h00000, 0, 0, 16'h0030);
    eng_busy = 1; idle(2);
    pulse_done(); eng_busy = 0;
    @(negedge clk); chk("R13", "mask cleared on done", blk_mask, 0);
    wr(18'h00000, 0, 0, 16'h00F0);

    // Block window aborted by a stray write
    cmd(0, 8'h80); unl(0);
    wr(18'h08000, 0, 0, 16'h0030);
    wr(18'h00000, 0, 0, 16'h0055);
    @(negedge clk); chk("R9", "stray write closes window", erase_window, 0);
    idle(TMO + 3);
    @(negedge clk); chk("R9", "no erase after abort", erase_active, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule